// File: doc/BRIEF.md
# Two-Port Shared Word Memory with Collision Arbitration

This block is a synchronous memory of 2048 words of 16 bits that two agents, called left and right, reach through two ports that are fully independent of each other. Each port has an active-low select, an active-low read enable, one active-low write strobe for each byte lane, a word address, write data, read data and an active-low busy flag. The two ports may read or write any word in the same cycle, including the same word.

When both selected ports point at the same word, a collision arbiter grants the word to one port and drives the busy flag of the other port low. While its flag is low, that port cannot write, but it can still read. The grant goes to the port that was already sitting on the word. If both ports arrive in the same cycle, the left port wins. The grant then holds for as long as the collision lasts. In slave mode (parameter `SLAVE=1`) the arbiter is left out. The busy flag of each port is then taken from an input, so that several instances can share one master's decision when they are placed side by side to build a wider word.

Top module: `dpa_dpram`

## Requirements
- R1: Each port addresses all 2048 words on its own, and a word written through a port can be read back through either port.
- R2: Write strobe bit 0 writes data bits 7:0 and strobe bit 1 writes bits 15:8, both active low. A lane whose strobe is high keeps its stored byte.
- R3: A port whose select is high does not write, and its read data is all zero.
- R4: A read-data byte lane carries the stored byte only when the port's select and read enable are both low and that lane's write strobe is high. Otherwise the lane reads zero.
- R5: In master mode a busy flag goes low only when both selects are low and the two addresses are equal. In every other case both flags are high.
- R6: The two busy flags are never low in the same cycle.
- R7: A port whose busy flag is low writes nothing, but its read data still shows the stored word.
- R8: At the start of a collision the winner is the port whose select was already low, on the same address, in the previous cycle while the other port's was not. Otherwise the left port wins. The grant is kept while the collision lasts.
- R9: A word written by the winning port shows up on the other port's read data in the next cycle.
- R10: With `SLAVE=1` each busy output equals its busy input, no arbitration takes place, and a low busy input blocks that port's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_sel_n | input | 1 | Left select, active low |
| l_rd_n | input | 1 | Left read enable, active low |
| l_wstb_n | input | 2 | Left byte write strobes, active low (bit 0 = low byte) |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_busy_in_n | input | 1 | Left busy input, used in slave mode only |
| l_rdata | output | 16 | Left read data |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_sel_n | input | 1 | Right select, active low |
| r_rd_n | input | 1 | Right read enable, active low |
| r_wstb_n | input | 2 | Right byte write strobes, active low (bit 0 = low byte) |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_busy_in_n | input | 1 | Right busy input, used in slave mode only |
| r_rdata | output | 16 | Right read data |
| r_busy_n | output | 1 | Right busy flag, active low |

## Verification
Random traffic is confined to eight addresses, so that collisions, simultaneous arrivals and reads of words the other side is writing come up often. A bench model of the arrival rule predicts every busy flag and every read lane, which separates correct grant ordering from a fixed-priority arbiter. Directed cases isolate three situations that random traffic cannot tell apart: a same-cycle arrival, where the left port must win; a late arrival by the left port, where the right port must win; and a single-lane write mixed with a read of the other lane. A slave instance is given an externally forced busy flag to show that it follows the input and does not arbitrate.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpa_arbiter.sv
module dpa_arbiter #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_act,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_act,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_busy_n,
  output logic              r_busy_n
);
  import dpa_pkg::*;

  owner_e            owner_q, owner_d, onset_win, winner;
  logic              l_prev_act_q, r_prev_act_q;
  logic [ADDR_W-1:0] l_prev_addr_q, r_prev_addr_q;
  logic              match, l_stay, r_stay;

  // next-state logic
  always_comb begin
    match     = l_act && r_act && (l_addr == r_addr);
    l_stay    = l_prev_act_q && (l_prev_addr_q == l_addr);
    r_stay    = r_prev_act_q && (r_prev_addr_q == r_addr);
    onset_win = (r_stay && !l_stay) ? OWN_RIGHT : OWN_LEFT;
    winner    = (owner_q == OWN_NONE) ? onset_win : owner_q;
    owner_d   = match ? winner : OWN_NONE;
    l_busy_n  = !(match && (winner == OWN_RIGHT));
    r_busy_n  = !(match && (winner == OWN_LEFT));
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q      <= OWN_NONE;
      l_prev_act_q <= 1'b0;
      r_prev_act_q <= 1'b0;
    end else begin
      owner_q      <= owner_d;
      l_prev_act_q <= l_act;
      r_prev_act_q <= r_act;
    end
  end

  // address history, clock-enabled by the port being active
  always_ff @(posedge clk) begin
    if (l_act) l_prev_addr_q <= l_addr;
    if (r_act) r_prev_addr_q <= r_addr;
  end

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n)); // R6
  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n || !r_busy_n) |-> (l_act && r_act && (l_addr == r_addr))); // R5
  AST_MATCH_GIVES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (l_act && r_act && (l_addr == r_addr)) |-> (!l_busy_n || !r_busy_n)); // R5
  AST_LEFT_GRANT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n |=> (!(l_act && r_act && (l_addr == r_addr)) || !r_busy_n)); // R8
  AST_RIGHT_GRANT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n |=> (!(l_act && r_act && (l_addr == r_addr)) || !l_busy_n)); // R8
endmodule

// File: rtl/dpa_port.sv
module dpa_port #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic [LANES-1:0]  wstb_n,
  input  logic              busy_n,
  input  logic [DATA_W-1:0] word,
  output logic              act,
  output logic [LANES-1:0]  wr_lane,
  output logic [DATA_W-1:0] rdata
);
  assign act = !sel_n;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wr_lane[i]        = !sel_n && busy_n && !wstb_n[i];
    assign rdata[i*8 +: 8]   = (!sel_n && !rd_n && wstb_n[i]) ? word[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/dpa_array.sv
module dpa_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic [LANES-1:0]  l_wr_lane,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic [LANES-1:0]  r_wr_lane,
  output logic [DATA_W-1:0] l_word,
  output logic [DATA_W-1:0] r_word
);
  for (genvar i = 0; i < LANES; i++) begin : g_bank
    logic [7:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (l_wr_lane[i]) bank[l_addr] <= l_wdata[i*8 +: 8];
      if (r_wr_lane[i]) bank[r_addr] <= r_wdata[i*8 +: 8];
    end

    assign l_word[i*8 +: 8] = bank[l_addr];
    assign r_word[i*8 +: 8] = bank[r_addr];
  end
endmodule

// File: rtl/dpa_dpram.sv
module dpa_dpram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter bit SLAVE  = 1'b0,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic              l_rd_n,
  input  logic [LANES-1:0]  l_wstb_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_busy_in_n,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_busy_n,
  input  logic              r_sel_n,
  input  logic              r_rd_n,
  input  logic [LANES-1:0]  r_wstb_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_busy_in_n,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_busy_n
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              l_act, r_act;
  logic [LANES-1:0]  l_wr_lane, r_wr_lane;
  logic [DATA_W-1:0] l_word, r_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  if (SLAVE) begin : g_slave
    assign l_busy_n = l_busy_in_n;
    assign r_busy_n = r_busy_in_n;
    logic unused_slave;
    assign unused_slave = ^{rst_int_n, l_act, r_act};
  end else begin : g_master
    dpa_arbiter #(.ADDR_W(ADDR_W)) u_arb (
      .clk(clk), .rst_n(rst_int_n),
      .l_act(l_act), .l_addr(l_addr),
      .r_act(r_act), .r_addr(r_addr),
      .l_busy_n(l_busy_n), .r_busy_n(r_busy_n)
    );
    logic unused_master;
    assign unused_master = ^{l_busy_in_n, r_busy_in_n};
  end

  dpa_port #(.DATA_W(DATA_W)) u_lport (
    .sel_n(l_sel_n), .rd_n(l_rd_n), .wstb_n(l_wstb_n), .busy_n(l_busy_n),
    .word(l_word), .act(l_act), .wr_lane(l_wr_lane), .rdata(l_rdata)
  );

  dpa_port #(.DATA_W(DATA_W)) u_rport (
    .sel_n(r_sel_n), .rd_n(r_rd_n), .wstb_n(r_wstb_n), .busy_n(r_busy_n),
    .word(r_word), .act(r_act), .wr_lane(r_wr_lane), .rdata(r_rdata)
  );

  dpa_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_wr_lane(l_wr_lane),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_wr_lane(r_wr_lane),
    .l_word(l_word), .r_word(r_word)
  );

  AST_LEFT_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !l_busy_n |-> (l_wr_lane == '0)); // R7
  AST_RIGHT_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !r_busy_n |-> (r_wr_lane == '0)); // R7
  AST_LEFT_DESELECT_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    l_sel_n |-> (l_rdata == '0 && l_wr_lane == '0)); // R3
  AST_RIGHT_DESELECT_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    r_sel_n |-> (r_rdata == '0 && r_wr_lane == '0)); // R3
endmodule

// File: tb/dpa_dpram_test.sv
module dpa_dpram_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        l_sel_n, l_rd_n, r_sel_n, r_rd_n;
  logic [1:0]  l_wstb_n, r_wstb_n;
  logic [10:0] l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata;
  logic        l_bin_n, r_bin_n;
  logic [15:0] l_rdata, r_rdata, sl_rdata, sr_rdata;
  logic        l_busy_n, r_busy_n, sl_busy_n, sr_busy_n;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  dpa_dpram uut (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_rd_n(l_rd_n), .l_wstb_n(l_wstb_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_busy_in_n(l_bin_n), .l_rdata(l_rdata), .l_busy_n(l_busy_n),
    .r_sel_n(r_sel_n), .r_rd_n(r_rd_n), .r_wstb_n(r_wstb_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_busy_in_n(r_bin_n), .r_rdata(r_rdata), .r_busy_n(r_busy_n)
  );

  dpa_dpram #(.SLAVE(1'b1)) uut_slv (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_rd_n(l_rd_n), .l_wstb_n(l_wstb_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_busy_in_n(l_bin_n), .l_rdata(sl_rdata), .l_busy_n(sl_busy_n),
    .r_sel_n(r_sel_n), .r_rd_n(r_rd_n), .r_wstb_n(r_wstb_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_busy_in_n(r_bin_n), .r_rdata(sr_rdata), .r_busy_n(sr_busy_n)
  );

  // reference model
  logic [15:0] mdl [0:2047];
  int          m_own;              // 0 none, 1 left, 2 right
  logic        m_lpa, m_rpa;
  logic [10:0] m_lpaddr, m_rpaddr;
  logic        e_lb, e_rb;
  int          e_own;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void calc();
    logic match, ls, rs;
    int win;
    match = !l_sel_n && !r_sel_n && (l_addr == r_addr);
    ls = m_lpa && (m_lpaddr == l_addr);
    rs = m_rpa && (m_rpaddr == r_addr);
    win = (m_own != 0) ? m_own : ((rs && !ls) ? 2 : 1);
    e_lb  = !(match && win == 2);
    e_rb  = !(match && win == 1);
    e_own = match ? win : 0;
  endfunction

  function automatic logic [15:0] exp_rd(logic sel_n, logic rd_n, logic [1:0] w, logic [10:0] a);
    logic [15:0] v;
    for (int i = 0; i < 2; i++)
      v[i*8 +: 8] = (!sel_n && !rd_n && w[i]) ? mdl[a][i*8 +: 8] : 8'h00;
    return v;
  endfunction

  // called at negedge after inputs set; returns at next negedge
  task automatic step();
    #2;
    calc();
    chk("R5 left busy", {15'd0, l_busy_n}, {15'd0, e_lb});
    chk("R5 right busy", {15'd0, r_busy_n}, {15'd0, e_rb});
    chk("R6 exclusive busy", {15'd0, (l_busy_n | r_busy_n)}, 16'd1);
    chk("R4 left rdata", l_rdata, exp_rd(l_sel_n, l_rd_n, l_wstb_n, l_addr));
    chk("R4 right rdata", r_rdata, exp_rd(r_sel_n, r_rd_n, r_wstb_n, r_addr));
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      if (!l_sel_n && e_lb && !l_wstb_n[i]) mdl[l_addr][i*8 +: 8] = l_wdata[i*8 +: 8];
      if (!r_sel_n && e_rb && !r_wstb_n[i]) mdl[r_addr][i*8 +: 8] = r_wdata[i*8 +: 8];
    end
    m_own = e_own;
    m_lpa = !l_sel_n; m_lpaddr = l_addr;
    m_rpa = !r_sel_n; m_rpaddr = r_addr;
    @(negedge clk);
  endtask

  task automatic setl(logic s, logic rd, logic [1:0] w, logic [10:0] a, logic [15:0] d);
    l_sel_n = s; l_rd_n = rd; l_wstb_n = w; l_addr = a; l_wdata = d;
  endtask
  task automatic setr(logic s, logic rd, logic [1:0] w, logic [10:0] a, logic [15:0] d);
    r_sel_n = s; r_rd_n = rd; r_wstb_n = w; r_addr = a; r_wdata = d;
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_own = 0; m_lpa = 1'b0; m_rpa = 1'b0; m_lpaddr = '0; m_rpaddr = '0;
    l_bin_n = 1'b1; r_bin_n = 1'b1;
    setl(1'b1, 1'b1, 2'b11, 11'd0, 16'h0);
    setr(1'b1, 1'b1, 2'b11, 11'd0, 16'h0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R3 reset left rdata", l_rdata, 16'h0);
    chk("R5 reset busy", {14'd0, l_busy_n, r_busy_n}, 16'h3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // preload: left 0..3 and 2047, right 4..7, whole words
    for (int k = 0; k < 4; k++) begin
      setl(1'b0, 1'b1, 2'b00, 11'(k), 16'h1100 + 16'(k));
      setr(1'b0, 1'b1, 2'b00, 11'(k + 4), 16'h2200 + 16'(k));
      step();
    end
    setl(1'b0, 1'b1, 2'b00, 11'd2047, 16'h7FF7); setr(1'b1, 1'b1, 2'b11, 11'd0, 16'h0);
    step();
    // R1 / R9: cross reads
    setl(1'b0, 1'b0, 2'b11, 11'd6, 16'h0); setr(1'b0, 1'b0, 2'b11, 11'd2047, 16'h0);
    #1;
    chk("R1 left reads right-written word", l_rdata, 16'h2202);
    chk("R9 right reads left-written top word", r_rdata, 16'h7FF7);
    step();

    // R2 / R4: low lane write while high lane read
    setl(1'b0, 1'b0, 2'b10, 11'd1, 16'hABCD); setr(1'b1, 1'b1, 2'b11, 11'd0, 16'h0);
    #1;
    chk("R4 low lane zero while written, high lane read", l_rdata, 16'h1100);
    step();
    setl(1'b0, 1'b0, 2'b11, 11'd1, 16'h0);
    #1;
    chk("R2 only low byte written", l_rdata, 16'h11CD);
    step();
    // R3: deselected write does nothing
    setl(1'b1, 1'b0, 2'b00, 11'd1, 16'h5555);
    #1; chk("R3 deselected rdata zero", l_rdata, 16'h0);
    step();
    setl(1'b0, 1'b0, 2'b11, 11'd1, 16'h0);
    #1; chk("R3 deselected write ignored", l_rdata, 16'h11CD);
    step();

    // R8: same-cycle arrival, left wins, both write
    setl(1'b1, 1'b1, 2'b11, 11'd0, 16'h0); setr(1'b1, 1'b1, 2'b11, 11'd0, 16'h0);
    step();
    setl(1'b0, 1'b1, 2'b00, 11'd3, 16'hAAAA); setr(1'b0, 1'b1, 2'b00, 11'd3, 16'hBBBB);
    #1;
    chk("R8 tie: right busy", {15'd0, r_busy_n}, 16'd0);
    chk("R8 tie: left free", {15'd0, l_busy_n}, 16'd1);
    step();
    setl(1'b1, 1'b1, 2'b11, 11'd0, 16'h0); setr(1'b0, 1'b0, 2'b11, 11'd3, 16'h0);
    #1; chk("R7 loser write blocked, winner landed", r_rdata, 16'hAAAA);
    step();
    // R8: right already there, left arrives late and loses
    setl(1'b0, 1'b0, 2'b00, 11'd3, 16'hCCCC);
    #1;
    chk("R8 late left is busy", {14'd0, l_busy_n, r_busy_n}, 16'h1);
    chk("R7 busy left still reads", l_rdata, 16'h0000);
    step();
    setl(1'b0, 1'b0, 2'b11, 11'd3, 16'h0); setr(1'b0, 1'b0, 2'b00, 11'd3, 16'h1234);
    #1;
    chk("R8 grant held", {14'd0, l_busy_n, r_busy_n}, 16'h1);
    chk("R7 busy left reads old word", l_rdata, 16'hAAAA);
    step();
    #1; chk("R9 winner write seen next cycle", l_rdata, 16'h1234);
    // R5: mismatch clears busy
    setr(1'b0, 1'b0, 2'b11, 11'd4, 16'h0);
    #1; chk("R5 mismatch both free", {14'd0, l_busy_n, r_busy_n}, 16'h3);
    step();

    // random traffic on 8 addresses
    for (int n = 0; n < 4000; n++) begin
      setl(($urandom % 5) == 0, ($urandom % 3) == 0, (($urandom % 2) != 0) ? 2'b11 : 2'($urandom),
           11'($urandom % 8), 16'($urandom));
      setr(($urandom % 5) == 0, ($urandom % 3) == 0, (($urandom % 2) != 0) ? 2'b11 : 2'($urandom),
           11'($urandom % 8), 16'($urandom));
      step();
    end

    // R10: slave follows busy inputs and blocks the left write
    setl(1'b1, 1'b1, 2'b11, 11'd0, 16'h0); setr(1'b1, 1'b1, 2'b11, 11'd0, 16'h0);
    step();
    l_bin_n = 1'b0; r_bin_n = 1'b1;
    setl(1'b0, 1'b1, 2'b00, 11'd9, 16'h0F0F); setr(1'b0, 1'b1, 2'b00, 11'd10, 16'hF0F0);
    #1;
    chk("R10 slave busy follows inputs", {14'd0, sl_busy_n, sr_busy_n}, 16'h1);
    chk("R10 master ignores busy inputs", {14'd0, l_busy_n, r_busy_n}, 16'h3);
    step();
    l_bin_n = 1'b1;
    setl(1'b0, 1'b1, 2'b00, 11'd10, 16'h0F0F); setr(1'b1, 1'b1, 2'b11, 11'd0, 16'h0);
    step();
    setl(1'b0, 1'b0, 2'b11, 11'd10, 16'h0); setr(1'b0, 1'b0, 2'b11, 11'd10, 16'h0);
    #1;
    chk("R10 slave no arbitration on match", {14'd0, sl_busy_n, sr_busy_n}, 16'h3);
    chk("R10 slave left write landed", sl_rdata, 16'h0F0F);
    step();
    l_bin_n = 1'b0;
    setl(1'b0, 1'b1, 2'b00, 11'd10, 16'h9999); setr(1'b1, 1'b1, 2'b11, 11'd0, 16'h0);
    step();
    l_bin_n = 1'b1;
    setl(1'b1, 1'b1, 2'b11, 11'd0, 16'h0); setr(1'b0, 1'b0, 2'b11, 11'd10, 16'h0);
    #1; chk("R10 slave busy input blocked write", sr_rdata, 16'h0F0F);
    step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule